// File: doc/BRIEF.md
# Lane Saturate, Extend and Pack Unit

A purely combinational 32-bit datapath block that reshapes the two 16-bit halves of a word. Software-visible lane instructions use it for three jobs. It can clamp each halfword of operand A to a programmable signed or unsigned bit width. It can pull bytes 0 and 2 out of operand B, after a byte rotate, widen them to halfwords with sign or zero fill, and optionally add them to the halfwords of operand A. It can also build a word from one half of operand A and one shifted half of operand B.

The operation is chosen by a 3-bit opcode. The result follows the inputs in the same cycle with no state, so the unit can sit inside an execute stage that supplies its own pipeline registers. Each operation ignores any input it does not use.

Top module: `lane_reshape_unit`

## Requirements
- R1: `op_i` selects the operation with this encoding: 0 signed saturate, 1 unsigned saturate, 2 sign extend, 3 zero extend, 4 sign extend and accumulate, 5 zero extend and accumulate, 6 bottom-top pack, 7 top-bottom pack. `res_o` reflects the inputs in the same cycle, and all-zero inputs give a zero result.
- R2: Signed saturate (op 0) clamps each halfword of `a_i`, read as signed, into the range -2^(n-1) to 2^(n-1)-1, where n = `sat_w_i` + 1 (1 to 16). For example, n = 8 turns 0x80030168 into 0xFF80007F.
- R3: Unsigned saturate (op 1) clamps each halfword of `a_i`, read as signed, into the range 0 to 2^n-1, where n = `sat_w_i` (0 to 15). Negative lanes become 0.
- R4: During either saturate operation, a halfword already inside the target range passes through unchanged.
- R5: Sign extend (op 2) widens byte 0 of the rotated `b_i` into result bits 15:0 and byte 2 into result bits 31:16. For example, 0x80830168 gives 0xFF830068.
- R6: Before the bytes are picked, `b_i` is rotated right by 8 × `rot_i` bits. For example, 0x80830168 gives 0xFF800001 for `rot_i` = 1, 0x0068FF83 for 2 and 0x0001FF80 for 3.
- R7: Zero extend (op 3) picks the same bytes as R5 and R6 but fills with zeros. For example, 0x80830168 gives 0x00830068.
- R8: The accumulate forms (op 4 and op 5) add each widened halfword to the matching halfword of `a_i` modulo 2^16. No carry passes between the two lanes.
- R9: Bottom-top pack (op 6) returns `a_i`[15:0] in the low half. The high half is bits 31:16 of `b_i` shifted left by `shamt_i` (0 to 31).
- R10: Top-bottom pack (op 7) returns `a_i`[31:16] in the high half. The low half is bits 15:0 of `b_i` arithmetically shifted right by `shamt_i`.
- R11: Inputs that the selected operation does not use have no effect on `res_o`. This covers `b_i`, `rot_i` and `shamt_i` while saturating, `sat_w_i` and `rot_i` while packing, and `a_i` in the non-accumulate extend forms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation select (encoding in R1) |
| a_i | input | 32 | Operand A: saturate source, accumulate addend, kept pack half |
| b_i | input | 32 | Operand B: extend source, shifted pack half |
| rot_i | input | 2 | Byte rotate count for the extend operations |
| shamt_i | input | 5 | Shift amount for the pack operations |
| sat_w_i | input | 4 | Saturation width field |
| res_o | output | 32 | Result word |

## Verification
The unit holds no registers, so every result is due in the cycle its stimulus is applied, with no latency to count. Each scenario task drives all inputs just after a rising clock edge and reads `res_o` at the following falling edge, half a period later. By then the combinational path has settled and the next stimulus has not yet been applied. The expected words are worked out by hand from the lane rules, including corner cases: the narrowest and widest widths, a zero-width unsigned clamp, lane wrap without cross-lane carry, and shifts of 0, 16 and 31.

// File: rtl/lane_reshape_pkg.sv
package lane_reshape_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SAT_S   = 3'd0,
    OP_SAT_U   = 3'd1,
    OP_EXT_S   = 3'd2,
    OP_EXT_U   = 3'd3,
    OP_EXTA_S  = 3'd4,
    OP_EXTA_U  = 3'd5,
    OP_PACK_BT = 3'd6,
    OP_PACK_TB = 3'd7
  } lane_op_e;
endpackage

// File: rtl/lane_sat.sv
module lane_sat #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0]         lane_i,
  input  logic [$clog2(LANE_W)-1:0] width_i,
  input  logic                      signed_i,
  output logic [LANE_W-1:0]         lane_o
);
  localparam int EXT_W = LANE_W + 2;

  logic signed [EXT_W-1:0] val, hi, lo;

  // signed: field holds n-1, so max = 2^field - 1; unsigned: field holds n
  always_comb begin
    val = {{2{lane_i[LANE_W-1]}}, lane_i};
    hi  = (EXT_W'(1) << width_i) - EXT_W'(1);
    lo  = signed_i ? (-hi - EXT_W'(1)) : '0;
    if (val > hi)      lane_o = hi[LANE_W-1:0];
    else if (val < lo) lane_o = lo[LANE_W-1:0];
    else               lane_o = lane_i;
  end
endmodule

// File: rtl/lane_extend.sv
module lane_extend #(
  parameter int LANE_W = 16,
  localparam int DATA_W  = 2 * LANE_W,
  localparam int BYTE_W  = LANE_W / 2,
  localparam int N_LANES = DATA_W / LANE_W,
  localparam int ROT_W   = $clog2(DATA_W / BYTE_W)
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] addend_i,
  input  logic [ROT_W-1:0]  rot_i,
  input  logic              signed_i,
  input  logic              acc_i,
  output logic [DATA_W-1:0] res_o
);
  logic [2*DATA_W-1:0] dbl;
  logic [DATA_W-1:0]   rotated;

  always_comb begin
    dbl     = {src_i, src_i} >> (rot_i * BYTE_W);
    rotated = dbl[DATA_W-1:0];
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] pick;
    logic              fill;
    logic [LANE_W-1:0] wide, addend;
    always_comb begin
      pick   = rotated[g*LANE_W +: BYTE_W];
      fill   = signed_i & pick[BYTE_W-1];
      wide   = {{(LANE_W-BYTE_W){fill}}, pick};
      addend = acc_i ? addend_i[g*LANE_W +: LANE_W] : '0;
      res_o[g*LANE_W +: LANE_W] = wide + addend;
    end
  end
endmodule

// File: rtl/lane_pack.sv
module lane_pack #(
  parameter int LANE_W = 16,
  localparam int DATA_W = 2 * LANE_W,
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic              top_bottom_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] shl, sar;

  always_comb begin
    shl = b_i << shamt_i;
    sar = $signed(b_i) >>> shamt_i;
    if (top_bottom_i) res_o = {a_i[DATA_W-1:LANE_W], sar[LANE_W-1:0]};
    else              res_o = {shl[DATA_W-1:LANE_W], a_i[LANE_W-1:0]};
  end
endmodule

// File: rtl/lane_reshape_unit.sv
module lane_reshape_unit
  import lane_reshape_pkg::*;
#(
  parameter int LANE_W = 16,
  localparam int DATA_W  = 2 * LANE_W,
  localparam int BYTE_W  = LANE_W / 2,
  localparam int N_LANES = DATA_W / LANE_W,
  localparam int ROT_W   = $clog2(DATA_W / BYTE_W),
  localparam int SH_W    = $clog2(DATA_W),
  localparam int W_BITS  = $clog2(LANE_W)
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [ROT_W-1:0]  rot_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [W_BITS-1:0] sat_w_i,
  output logic [DATA_W-1:0] res_o
);
  lane_op_e          op;
  logic              sat_signed, ext_signed, ext_acc, pack_tb;
  logic [DATA_W-1:0] sat_res, ext_res, pack_res;

  always_comb begin
    op         = lane_op_e'(op_i);
    sat_signed = (op == OP_SAT_S);
    ext_signed = (op == OP_EXT_S) || (op == OP_EXTA_S);
    ext_acc    = (op == OP_EXTA_S) || (op == OP_EXTA_U);
    pack_tb    = (op == OP_PACK_TB);
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_sat
    lane_sat #(.LANE_W(LANE_W)) u_sat (
      .lane_i  (a_i[g*LANE_W +: LANE_W]),
      .width_i (sat_w_i),
      .signed_i(sat_signed),
      .lane_o  (sat_res[g*LANE_W +: LANE_W])
    );
  end

  lane_extend #(.LANE_W(LANE_W)) u_ext (
    .src_i   (b_i),
    .addend_i(a_i),
    .rot_i   (rot_i),
    .signed_i(ext_signed),
    .acc_i   (ext_acc),
    .res_o   (ext_res)
  );

  lane_pack #(.LANE_W(LANE_W)) u_pack (
    .a_i         (a_i),
    .b_i         (b_i),
    .shamt_i     (shamt_i),
    .top_bottom_i(pack_tb),
    .res_o       (pack_res)
  );

  always_comb begin
    unique case (op)
      OP_SAT_S, OP_SAT_U:     res_o = sat_res;
      OP_PACK_BT, OP_PACK_TB: res_o = pack_res;
      default:                res_o = ext_res;
    endcase
  end
endmodule

// File: rtl/lane_reshape_chk.sv
module lane_reshape_chk
  import lane_reshape_pkg::*;
#(
  parameter int LANE_W = 16,
  localparam int DATA_W = 2 * LANE_W,
  localparam int BYTE_W = LANE_W / 2,
  localparam int W_BITS = $clog2(LANE_W)
) (
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [W_BITS-1:0] sat_w_i,
  input logic [DATA_W-1:0] res_o
);
  always_comb begin
    for (int g = 0; g < 2; g++) begin
      int lane_out, lane_in, lane_u, hi_v;
      lane_out = int'($signed(res_o[g*LANE_W +: LANE_W]));
      lane_in  = int'($signed(a_i[g*LANE_W +: LANE_W]));
      lane_u   = int'(res_o[g*LANE_W +: LANE_W]);
      hi_v     = (1 << sat_w_i) - 1;
      if (op_i == OP_SAT_S) begin
        assert_sat_s_range_R2: assert (lane_out <= hi_v && lane_out >= -hi_v - 1);
        if (lane_in <= hi_v && lane_in >= -hi_v - 1)
          assert_sat_s_pass_R4: assert (lane_out == lane_in);
      end
      if (op_i == OP_SAT_U) begin
        assert_sat_u_range_R3: assert (lane_u <= hi_v);
        if (lane_in >= 0 && lane_in <= hi_v)
          assert_sat_u_pass_R4: assert (lane_u == lane_in);
      end
      if (op_i == OP_EXT_S)
        assert_sext_fill_R5: assert (res_o[g*LANE_W+BYTE_W +: BYTE_W] ==
                                     {BYTE_W{res_o[g*LANE_W+BYTE_W-1]}});
      if (op_i == OP_EXT_U)
        assert_zext_fill_R7: assert (res_o[g*LANE_W+BYTE_W +: BYTE_W] == '0);
    end
    if (op_i == OP_PACK_BT)
      assert_pack_bt_low_R9: assert (res_o[LANE_W-1:0] == a_i[LANE_W-1:0]);
    if (op_i == OP_PACK_TB)
      assert_pack_tb_high_R10: assert (res_o[DATA_W-1:LANE_W] == a_i[DATA_W-1:LANE_W]);
  end
endmodule

bind lane_reshape_unit lane_reshape_chk #(.LANE_W(LANE_W)) u_chk (
  .op_i   (op_i),
  .a_i    (a_i),
  .sat_w_i(sat_w_i),
  .res_o  (res_o)
);

// File: tb/tb_lane_reshape_unit.sv
module tb_lane_reshape_unit;
  localparam logic [2:0] SAT_S = 3'd0, SAT_U = 3'd1, EXT_S = 3'd2, EXT_U = 3'd3;
  localparam logic [2:0] EXTA_S = 3'd4, EXTA_U = 3'd5, PACK_BT = 3'd6, PACK_TB = 3'd7;

  logic        clk = 1'b0;
  logic [2:0]  op;
  logic [31:0] a, b, res;
  logic [1:0]  rot;
  logic [4:0]  shamt;
  logic [3:0]  sat_w;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 1'b0;

  always #10 clk = ~clk;

  lane_reshape_unit dut (
    .op_i(op), .a_i(a), .b_i(b), .rot_i(rot),
    .shamt_i(shamt), .sat_w_i(sat_w), .res_o(res)
  );

  task automatic run(input string tag, input logic [2:0] o, input logic [31:0] av,
                     input logic [31:0] bv, input logic [1:0] r, input logic [4:0] s,
                     input logic [3:0] w, input logic [31:0] exp);
    @(posedge clk);
    op = o; a = av; b = bv; rot = r; shamt = s; sat_w = w;
    @(negedge clk);
    n_checks++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, res, exp);
    end
  endtask

  task automatic t_idle;
    run("R1 zero inputs", SAT_S, 32'h0, 32'h0, 2'd0, 5'd0, 4'd0, 32'h0);
  endtask

  task automatic t_sat_signed;
    run("R2 width 8", SAT_S, 32'h80030168, 32'h0, 2'd0, 5'd0, 4'd7, 32'hFF80007F);
    run("R2 width 1", SAT_S, 32'h80000005, 32'h0, 2'd0, 5'd0, 4'd0, 32'hFFFF0000);
  endtask

  task automatic t_sat_unsigned;
    run("R3 width 8", SAT_U, 32'h80030168, 32'h0, 2'd0, 5'd0, 4'd8, 32'h000000FF);
    run("R3 width 15", SAT_U, 32'h7FFF8000, 32'h0, 2'd0, 5'd0, 4'd15, 32'h7FFF0000);
    run("R3 width 0", SAT_U, 32'h12340001, 32'h0, 2'd0, 5'd0, 4'd0, 32'h0);
  endtask

  task automatic t_in_range;
    run("R4 signed edges", SAT_S, 32'h007FFF80, 32'h0, 2'd0, 5'd0, 4'd7, 32'h007FFF80);
    run("R4 signed full", SAT_S, 32'h80007FFF, 32'h0, 2'd0, 5'd0, 4'd15, 32'h80007FFF);
    run("R4 unsigned edge", SAT_U, 32'h00FF0000, 32'h0, 2'd0, 5'd0, 4'd8, 32'h00FF0000);
  endtask

  task automatic t_ext_signed;
    run("R5 sign extend", EXT_S, 32'h0, 32'h80830168, 2'd0, 5'd0, 4'd0, 32'hFF830068);
  endtask

  task automatic t_rotate;
    run("R6 rotate 8", EXT_S, 32'h0, 32'h80830168, 2'd1, 5'd0, 4'd0, 32'hFF800001);
    run("R6 rotate 16", EXT_S, 32'h0, 32'h80830168, 2'd2, 5'd0, 4'd0, 32'h0068FF83);
    run("R6 rotate 24", EXT_S, 32'h0, 32'h80830168, 2'd3, 5'd0, 4'd0, 32'h0001FF80);
  endtask

  task automatic t_ext_unsigned;
    run("R7 zero extend", EXT_U, 32'h0, 32'h80830168, 2'd0, 5'd0, 4'd0, 32'h00830068);
    run("R7 zero extend rot 24", EXT_U, 32'h0, 32'h80830168, 2'd3, 5'd0, 4'd0, 32'h00010080);
  endtask

  task automatic t_accumulate;
    run("R8 signed acc", EXTA_S, 32'h000D0008, 32'h80830168, 2'd0, 5'd0, 4'd0, 32'hFF900070);
    run("R8 unsigned acc", EXTA_U, 32'h000D0008, 32'h80830168, 2'd0, 5'd0, 4'd0, 32'h00900070);
    run("R8 signed acc rot 8", EXTA_S, 32'h000A000A, 32'h80830168, 2'd1, 5'd0, 4'd0, 32'hFF8A000B);
    run("R8 lane wrap no carry", EXTA_U, 32'h0001FFFF, 32'h00000001, 2'd0, 5'd0, 4'd0, 32'h00010000);
  endtask

  task automatic t_pack_bt;
    run("R9 shift 4", PACK_BT, 32'h00000111, 32'h22200000, 2'd0, 5'd4, 4'd0, 32'h22000111);
    run("R9 shift 0", PACK_BT, 32'h00000111, 32'h22200000, 2'd0, 5'd0, 4'd0, 32'h22200111);
    run("R9 shift 16", PACK_BT, 32'h00001234, 32'h0000ABCD, 2'd0, 5'd16, 4'd0, 32'hABCD1234);
  endtask

  task automatic t_pack_tb;
    run("R10 shift 4", PACK_TB, 32'h11100000, 32'h00000222, 2'd0, 5'd4, 4'd0, 32'h11100022);
    run("R10 shift 16 sign", PACK_TB, 32'h12340000, 32'h80000000, 2'd0, 5'd16, 4'd0, 32'h12348000);
    run("R10 shift 31 sign", PACK_TB, 32'h12340000, 32'h80000000, 2'd0, 5'd31, 4'd0, 32'h1234FFFF);
  endtask

  task automatic t_ignored;
    run("R11 sat ignores b rot shamt", SAT_S, 32'h80030168, 32'hFFFFFFFF, 2'd3, 5'd31, 4'd7, 32'hFF80007F);
    run("R11 pack ignores width rot", PACK_BT, 32'h00000111, 32'h22200000, 2'd3, 5'd4, 4'd15, 32'h22000111);
    run("R11 extend ignores a", EXT_S, 32'hFFFFFFFF, 32'h80830168, 2'd0, 5'd9, 4'd5, 32'hFF830068);
  endtask

  initial begin
    op = '0; a = '0; b = '0; rot = '0; shamt = '0; sat_w = '0;
    t_idle();
    t_sat_signed();
    t_sat_unsigned();
    t_in_range();
    t_ext_signed();
    t_rotate();
    t_ext_unsigned();
    t_accumulate();
    t_pack_bt();
    t_pack_tb();
    t_ignored();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule